// File: doc/BRIEF.md
# Policy-Driven Configuration Register Bank

This block holds a handful of configuration fields behind a 32-bit register port. Each field carries an access policy fixed at elaboration time: plain read/write, write-1-to-clear event bits, lockable fields, key bits that freeze other fields, write-once fields, a write-only command that emits a side-effect pulse, and a volatile field that hardware may change at any time. Each policy also picks a reset domain. Sticky fields survive a warm reset and return to default only on a cold reset. All other fields return to default on either reset.

Software writes go through `wr_en`, `addr`, `wdata` and `be`. Reads are combinational from `addr`. Hardware reports events through per-field set and clear vectors. It observes every field through `fld_val_o`. Keys are wired to the fields they protect, and a key can itself be locked by an upstream key, which forms a lock chain. The field map is held in a package table, and the generate logic builds one field engine for each entry.

Register layout:
- reg0: event-sticky [7:0], event [15:8], trim [23:16] (default 0x5A).
- reg1: cfgA [7:0] (default 0x11), volatile [15:8], sub-key [16], cfgB [31:24] (default 0x22).
- reg2: once-A [7:0] (default 0xA5), once-B [23:16] (default 0x0F).
- reg3: once-sticky [7:0] (default 0x3C), command [15:8], master key [31].

Field numbers, in order: event-sticky 0, event 1, trim 2, cfgA 3, volatile 4, sub-key 5, cfgB 6, once-A 7, once-B 8, once-sticky 9, master key 10, command 11. Field k appears on `fld_val_o[8k+:8]`, `hw_set[8k+:8]`, `hw_clr[8k+:8]` and `fld_pulse_o[k]`.

Top module: `cfg_policy_bank`

## Requirements
- R1: A write-1-to-clear field (fields 0 and 1) clears each bit that is written as 1 in an enabled byte. A bit written as 0 is unchanged. A bit of `hw_set[8k+:8]` sets the matching field bit one cycle later.
- R2: When a hardware set and a software clear hit the same bit of a write-1-to-clear field in the same cycle, the bit ends up set.
- R3: Sticky fields (0, 2 and 9) keep their value through a warm reset and no write takes effect while a warm reset is held. Non-sticky fields return to their defaults on a warm reset.
- R4: A write changes only the bytes whose `be` bit is 1. `be[n]` covers `wdata[8n+7:8n]`.
- R5: The master key (reg3 bit 31) locks itself only once it leaves its default of 0. Writing 0 to it does not lock. Once it is 1, software writes to it and to cfgA, the volatile field and the sub-key are dropped.
- R6: The sub-key (reg1 bit 16, field 5), when 1, makes cfgB read-only. The master key can freeze the sub-key itself, so the two locks form a chain.
- R7: The volatile field (field 4) follows hardware set and clear even while it is locked. When a set and a clear hit the same bit, the set wins.
- R8: A write-once field reads its default until the first write to its word after reset. After that, later writes are ignored.
- R9: The first write with any byte enable to a word captures every write-once field in that word at once. The bytes that write does not enable stay at their defaults for good.
- R10: Non-sticky write-once fields (reg2) re-arm on a warm reset. The sticky one (reg3 [7:0]) re-arms only on a cold reset.
- R11: The command field (reg3 [15:8], field 11) always reads as 0. A write that enables its byte raises `fld_pulse_o[11]` for exactly the next cycle, with the written byte on field 11 of `fld_val_o`.
- R12: A warm reset releases a lock held by the master key, which is non-sticky.
- R13: After a cold reset the registers read 0x005A0000, 0x22000011, 0x000F00A5 and 0x0000003C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold | input | 1 | Synchronous cold reset; resets every field, including sticky ones |
| rst_warm | input | 1 | Synchronous warm reset; resets only non-sticky fields |
| wr_en | input | 1 | Software write strobe |
| addr | input | 2 | Register select for reads and writes |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables for the write |
| hw_set | input | 96 | Per-field hardware set bits, 8 per field |
| hw_clr | input | 96 | Per-field hardware clear bits, 8 per field |
| rdata | output | 32 | Read view of the register at `addr` |
| fld_val_o | output | 96 | Current value of every field, 8 bits per field |
| fld_pulse_o | output | 12 | One-cycle write strobes of write-only fields |

## Verification
The checker watches several rules on every cycle:
- hardware sets always land in the event and volatile fields;
- a set master key or sub-key freezes what it guards;
- a captured write-once value never moves;
- a sticky field is unchanged across a warm reset;
- a command write always produces its pulse;
- the command byte always reads as zero.

Other behaviour only the bench scenarios can show. This covers the exact effect of partial byte enables on a write-once word, and that writing the default to the master key does not lock it. It also covers the re-arm rules of the two reset domains and the release of locks by a warm reset.

// File: rtl/cfg_policy_pkg.sv
package cfg_policy_pkg;

    localparam int REG_W      = 32;
    localparam int AW         = 2;
    localparam int NREGS      = 1 << AW;
    localparam int FW         = 8;
    localparam int NUM_FIELDS = 12;

    typedef enum logic [2:0] {
        POL_RW   = 3'd0,
        POL_RWV  = 3'd1,
        POL_W1C  = 3'd2,
        POL_ONCE = 3'd3,
        POL_WO   = 3'd4
    } pol_e;

    typedef struct packed {
        logic [1:0] reg_idx;
        logic [4:0] lsb;
        logic [3:0] width;
        pol_e       pol;
        logic       sticky;
        logic [7:0] dflt;
        logic       has_lock;
        logic [3:0] lock_src;
        logic       self_lock;
    } fdesc_t;

    // field numbers
    localparam int F_EVT_S  = 0;
    localparam int F_EVT    = 1;
    localparam int F_TRIM   = 2;
    localparam int F_CFGA   = 3;
    localparam int F_VOL    = 4;
    localparam int F_SUBKEY = 5;
    localparam int F_CFGB   = 6;
    localparam int F_ONCEA  = 7;
    localparam int F_ONCEB  = 8;
    localparam int F_ONCES  = 9;
    localparam int F_MKEY   = 10;
    localparam int F_CMD    = 11;

    function automatic fdesc_t mk(int r, int l, int w, pol_e p, bit s, int d,
                                  bit hl, int src, bit sl);
        fdesc_t f;
        f.reg_idx   = 2'(r);
        f.lsb       = 5'(l);
        f.width     = 4'(w);
        f.pol       = p;
        f.sticky    = s;
        f.dflt      = 8'(d);
        f.has_lock  = hl;
        f.lock_src  = 4'(src);
        f.self_lock = sl;
        return f;
    endfunction

    localparam fdesc_t FMAP [NUM_FIELDS] = '{
        mk(0,  0, 8, POL_W1C,  1'b1, 8'h00, 1'b0, 0,        1'b0),
        mk(0,  8, 8, POL_W1C,  1'b0, 8'h00, 1'b0, 0,        1'b0),
        mk(0, 16, 8, POL_RW,   1'b1, 8'h5A, 1'b0, 0,        1'b0),
        mk(1,  0, 8, POL_RW,   1'b0, 8'h11, 1'b1, F_MKEY,   1'b0),
        mk(1,  8, 8, POL_RWV,  1'b0, 8'h00, 1'b1, F_MKEY,   1'b0),
        mk(1, 16, 1, POL_RW,   1'b0, 8'h00, 1'b1, F_MKEY,   1'b0),
        mk(1, 24, 8, POL_RW,   1'b0, 8'h22, 1'b1, F_SUBKEY, 1'b0),
        mk(2,  0, 8, POL_ONCE, 1'b0, 8'hA5, 1'b0, 0,        1'b0),
        mk(2, 16, 8, POL_ONCE, 1'b0, 8'h0F, 1'b0, 0,        1'b0),
        mk(3,  0, 8, POL_ONCE, 1'b1, 8'h3C, 1'b0, 0,        1'b0),
        mk(3, 31, 1, POL_RW,   1'b0, 8'h00, 1'b0, 0,        1'b1),
        mk(3,  8, 8, POL_WO,   1'b0, 8'h00, 1'b0, 0,        1'b0)
    };

    function automatic logic [NREGS-1:0] once_word_mask();
        logic [NREGS-1:0] m = '0;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (FMAP[i].pol == POL_ONCE) m[FMAP[i].reg_idx] = 1'b1;
        return m;
    endfunction

    function automatic logic [NREGS-1:0] once_sticky_mask();
        logic [NREGS-1:0] m = '0;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (FMAP[i].pol == POL_ONCE && FMAP[i].sticky) m[FMAP[i].reg_idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/cfg_field.sv
module cfg_field
    import cfg_policy_pkg::*;
#(
    parameter int           W      = 8,
    parameter int           FLD_W  = 8,
    parameter pol_e         POL    = POL_RW,
    parameter bit           STICKY = 1'b0,
    parameter logic [FLD_W-1:0] DFLT = '0
) (
    input  logic             clk,
    input  logic             rst_cold,
    input  logic             rst_warm,
    input  logic             wr_hit,
    input  logic [FLD_W-1:0] wr_mask,
    input  logic [FLD_W-1:0] wr_data,
    input  logic             locked,
    input  logic             once_open,
    input  logic [FLD_W-1:0] hw_set,
    input  logic [FLD_W-1:0] hw_clr,
    output logic [FLD_W-1:0] val_o,
    output logic [FLD_W-1:0] rd_o,
    output logic             pulse_o
);
    localparam logic [FLD_W-1:0] MASK    = FLD_W'((1 << W) - 1);
    localparam logic [FLD_W-1:0] RST_VAL = (POL == POL_WO) ? '0 : (DFLT & MASK);

    logic [FLD_W-1:0] q, q_nxt, merged;
    logic             pulse_q;

    assign merged = (q & ~wr_mask) | (wr_data & wr_mask);

    always_comb begin
        q_nxt = q;
        case (POL)
            POL_RW:   if (wr_hit && !locked) q_nxt = merged;
            POL_RWV: begin
                if (wr_hit && !locked) q_nxt = merged;
                q_nxt = (q_nxt & ~hw_clr) | hw_set;
            end
            POL_W1C:  q_nxt = (q & ~(wr_hit ? (wr_data & wr_mask) : '0)) | hw_set;
            POL_ONCE: if (wr_hit && once_open) q_nxt = merged;
            POL_WO:   q_nxt = wr_hit ? (wr_data & wr_mask) : '0;
            default:  q_nxt = q;
        endcase
        q_nxt = q_nxt & MASK;
    end

    always_ff @(posedge clk) begin
        if (rst_cold || (rst_warm && !STICKY)) begin
            q       <= RST_VAL;
            pulse_q <= 1'b0;
        end else if (rst_warm) begin
            q       <= q;
            pulse_q <= 1'b0;
        end else begin
            q       <= q_nxt;
            pulse_q <= (POL == POL_WO) && wr_hit && (|(wr_mask & MASK));
        end
    end

    assign val_o   = q;
    assign rd_o    = (POL == POL_WO) ? '0 : q;
    assign pulse_o = pulse_q;
endmodule

// File: rtl/cfg_once_track.sv
module cfg_once_track #(
    parameter int              NREG        = 4,
    parameter int              ADDR_W      = 2,
    parameter logic [NREG-1:0] ONCE_MASK   = '0,
    parameter logic [NREG-1:0] STICKY_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_cold,
    input  logic              rst_warm,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              any_be,
    output logic [NREG-1:0]   open_o
);
    for (genvar r = 0; r < NREG; r++) begin : g_word
        if (ONCE_MASK[r]) begin : g_trk
            logic done_q;
            always_ff @(posedge clk) begin
                if (rst_cold || (rst_warm && !STICKY_MASK[r]))
                    done_q <= 1'b0;
                else if (!rst_warm && wr_en && any_be && addr == ADDR_W'(r))
                    done_q <= 1'b1;
            end
            assign open_o[r] = !done_q;
        end else begin : g_none
            assign open_o[r] = 1'b1;
        end
    end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_policy_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLD_W  = 8,
    parameter int NFLD   = 12,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NFLD-1:0][FLD_W-1:0]  rdv,
    output logic [DATA_W-1:0]           rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NFLD; i++)
            if (addr == ADDR_W'(FMAP[i].reg_idx))
                rdata = rdata | (DATA_W'(rdv[i]) << FMAP[i].lsb);
    end
endmodule

// File: rtl/cfg_policy_bank.sv
module cfg_policy_bank
    import cfg_policy_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int ADDR_W = AW,
    parameter int FLD_W  = FW,
    parameter int NFLD   = NUM_FIELDS
) (
    input  logic                    clk,
    input  logic                    rst_cold,
    input  logic                    rst_warm,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [DATA_W/8-1:0]     be,
    input  logic [NFLD*FLD_W-1:0]   hw_set,
    input  logic [NFLD*FLD_W-1:0]   hw_clr,
    output logic [DATA_W-1:0]       rdata,
    output logic [NFLD*FLD_W-1:0]   fld_val_o,
    output logic [NFLD-1:0]         fld_pulse_o
);
    localparam int BE_W = DATA_W / 8;
    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0]          wmask;
    logic [NREG-1:0]            once_open;
    logic [NFLD-1:0]            key_on, locked, pulse;
    logic [NFLD-1:0][FLD_W-1:0] val, rdv;

    always_comb begin
        for (int b = 0; b < BE_W; b++) wmask[b*8 +: 8] = {8{be[b]}};
    end

    for (genvar i = 0; i < NFLD; i++) begin : g_fld
        localparam fdesc_t D = FMAP[i];
        logic hit, lk_ext, lk_self;

        assign hit = wr_en && (addr == ADDR_W'(D.reg_idx));

        if (D.has_lock) begin : g_lk
            assign lk_ext = key_on[D.lock_src];
        end else begin : g_nolk
            assign lk_ext = 1'b0;
        end

        if (D.self_lock) begin : g_self
            assign lk_self = (val[i] != FLD_W'(D.dflt));
        end else begin : g_noself
            assign lk_self = 1'b0;
        end

        assign locked[i] = lk_ext | lk_self;
        assign key_on[i] = |val[i];

        cfg_field #(
            .W      (int'(D.width)),
            .FLD_W  (FLD_W),
            .POL    (D.pol),
            .STICKY (D.sticky),
            .DFLT   (FLD_W'(D.dflt))
        ) u_fld (
            .clk       (clk),
            .rst_cold  (rst_cold),
            .rst_warm  (rst_warm),
            .wr_hit    (hit),
            .wr_mask   (FLD_W'(wmask >> D.lsb)),
            .wr_data   (FLD_W'(wdata >> D.lsb)),
            .locked    (locked[i]),
            .once_open (once_open[D.reg_idx]),
            .hw_set    (hw_set[i*FLD_W +: FLD_W]),
            .hw_clr    (hw_clr[i*FLD_W +: FLD_W]),
            .val_o     (val[i]),
            .rd_o      (rdv[i]),
            .pulse_o   (pulse[i])
        );
    end

    cfg_once_track #(
        .NREG        (NREG),
        .ADDR_W      (ADDR_W),
        .ONCE_MASK   (NREG'(once_word_mask())),
        .STICKY_MASK (NREG'(once_sticky_mask()))
    ) u_once (
        .clk      (clk),
        .rst_cold (rst_cold),
        .rst_warm (rst_warm),
        .wr_en    (wr_en),
        .addr     (addr),
        .any_be   (|be),
        .open_o   (once_open)
    );

    cfg_read_mux #(
        .DATA_W (DATA_W),
        .FLD_W  (FLD_W),
        .NFLD   (NFLD),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .addr  (addr),
        .rdv   (rdv),
        .rdata (rdata)
    );

    assign fld_val_o   = val;
    assign fld_pulse_o = pulse;
endmodule

// File: rtl/cfg_policy_bank_chk.sv
module cfg_policy_bank_chk
    import cfg_policy_pkg::*;
(
    input logic                     clk,
    input logic                     rst_cold,
    input logic                     rst_warm,
    input logic                     wr_en,
    input logic [AW-1:0]            addr,
    input logic [REG_W/8-1:0]       be,
    input logic [NUM_FIELDS*FW-1:0] hw_set,
    input logic [NUM_FIELDS*FW-1:0] hw_clr,
    input logic [REG_W-1:0]         rdata,
    input logic [NUM_FIELDS*FW-1:0] fld_val_o,
    input logic [NUM_FIELDS-1:0]    fld_pulse_o
);
    // R1/R2: a hardware set on the sticky event field always lands
    p_evt_set_r2: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        (hw_set[F_EVT_S*FW +: FW] != '0) |=>
        ((fld_val_o[F_EVT_S*FW +: FW] & $past(hw_set[F_EVT_S*FW +: FW]))
            == $past(hw_set[F_EVT_S*FW +: FW])));

    // R7: volatile set lands even under lock
    p_vol_set_r7: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        (hw_set[F_VOL*FW +: FW] != '0) |=>
        ((fld_val_o[F_VOL*FW +: FW] & $past(hw_set[F_VOL*FW +: FW]))
            == $past(hw_set[F_VOL*FW +: FW])));

    // R7: volatile clear without a competing set lands
    p_vol_clr_r7: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        ((hw_clr[F_VOL*FW +: FW] & ~hw_set[F_VOL*FW +: FW]) != '0) |=>
        ((fld_val_o[F_VOL*FW +: FW] & $past(hw_clr[F_VOL*FW +: FW] & ~hw_set[F_VOL*FW +: FW]))
            == '0));

    // R5: master key freezes cfgA and holds itself
    p_master_lock_r5: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        fld_val_o[F_MKEY*FW] |=> $stable(fld_val_o[F_CFGA*FW +: FW]));

    p_master_self_r5: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        fld_val_o[F_MKEY*FW] |=> fld_val_o[F_MKEY*FW]);

    // R6: sub-key freezes cfgB
    p_subkey_lock_r6: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        fld_val_o[F_SUBKEY*FW] |=> $stable(fld_val_o[F_CFGB*FW +: FW]));

    // R8: a captured write-once value does not move
    p_once_freeze_r8: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        (fld_val_o[F_ONCEA*FW +: FW] != 8'hA5) |=> $stable(fld_val_o[F_ONCEA*FW +: FW]));

    // R3: sticky trim survives a warm reset
    p_sticky_warm_r3: assert property (@(posedge clk) disable iff (rst_cold)
        rst_warm |=> $stable(fld_val_o[F_TRIM*FW +: FW]));

    // R11: command write pulses next cycle, command byte reads zero
    p_wo_pulse_r11: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        (wr_en && addr == 2'd3 && be[1]) |=> fld_pulse_o[F_CMD]);

    p_wo_rdzero_r11: assert property (@(posedge clk) disable iff (rst_cold)
        (addr == 2'd3) |-> (rdata[15:8] == 8'h00));
endmodule

bind cfg_policy_bank cfg_policy_bank_chk u_chk (
    .clk         (clk),
    .rst_cold    (rst_cold),
    .rst_warm    (rst_warm),
    .wr_en       (wr_en),
    .addr        (addr),
    .be          (be),
    .hw_set      (hw_set),
    .hw_clr      (hw_clr),
    .rdata       (rdata),
    .fld_val_o   (fld_val_o),
    .fld_pulse_o (fld_pulse_o)
);

// File: tb/tb_cfg_policy_bank.sv
module tb_cfg_policy_bank;
    import cfg_policy_pkg::*;

    logic        clk = 1'b0;
    logic        rst_cold, rst_warm, wr_en;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [95:0] hw_set, hw_clr;
    logic [31:0] rdata;
    logic [95:0] fld_val_o;
    logic [11:0] fld_pulse_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        int          kind;   // 0 read, 1 field value, 2 pulse
        int          idx;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #4 clk = ~clk;

    cfg_policy_bank dut (
        .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .be(be), .hw_set(hw_set), .hw_clr(hw_clr),
        .rdata(rdata), .fld_val_o(fld_val_o), .fld_pulse_o(fld_pulse_o)
    );

    // monitor: compares every queued expectation just after a falling edge
    initial begin
        item_t       it;
        logic [31:0] act;
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                it = sbq.pop_front();
                case (it.kind)
                    0:       act = rdata;
                    1:       act = {24'h0, fld_val_o[it.idx*8 +: 8]};
                    default: act = {31'h0, fld_pulse_o[it.idx]};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: kind %0d idx %0d actual %h expected %h",
                             it.tag, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
        wr_en = 1'b1; addr = a; wdata = d; be = b;
        tick();
        wr_en = 1'b0; be = 4'h0;
    endtask

    task automatic hw(input int f, input logic [7:0] s, input logic [7:0] c);
        hw_set[f*8 +: 8] = s; hw_clr[f*8 +: 8] = c;
        tick();
        hw_set = '0; hw_clr = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
        addr = a;
        sbq.push_back('{0, 0, e, t});
        tick();
    endtask

    task automatic chk_val(input int f, input logic [7:0] e, input string t);
        sbq.push_back('{1, f, {24'h0, e}, t});
    endtask

    task automatic chk_pulse(input int f, input logic e, input string t);
        sbq.push_back('{2, f, {31'h0, e}, t});
    endtask

    task automatic cold_rst();
        rst_cold = 1'b1; tick(); tick(); rst_cold = 1'b0;
    endtask

    task automatic warm_rst();
        rst_warm = 1'b1; tick(); tick(); rst_warm = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_cold = 1'b1; rst_warm = 1'b0; wr_en = 1'b0;
        addr = 2'd0; wdata = '0; be = '0; hw_set = '0; hw_clr = '0;
        repeat (3) tick();
        rst_cold = 1'b0;

        // R13 reset view
        rd(0, 32'h005A0000, "R13");
        rd(1, 32'h22000011, "R13");
        rd(2, 32'h000F00A5, "R13");
        rd(3, 32'h0000003C, "R13");

        // R4 byte enables
        wr(0, 32'h00C30000, 4'b0100);
        rd(0, 32'h00C30000, "R4");
        wr(1, 32'h44000033, 4'b0001);
        rd(1, 32'h22000033, "R4");

        // R1 write-1-to-clear
        hw(F_EVT_S, 8'h81, 8'h00);
        hw(F_EVT,   8'h0F, 8'h00);
        rd(0, 32'h00C30F81, "R1");
        wr(0, 32'h00000301, 4'b0011);
        rd(0, 32'h00C30C80, "R1");

        // R2 hardware set beats software clear
        hw_set[F_EVT_S*8 +: 8] = 8'h80;
        wr(0, 32'h00000080, 4'b0001);
        hw_set = '0;
        rd(0, 32'h00C30C80, "R2");

        // R3 warm reset domains
        warm_rst();
        rd(0, 32'h00C30080, "R3");
        rd(1, 32'h22000011, "R3");

        // R8 / R9 / R10 write-once
        wr(2, 32'h00770066, 4'b0001);
        rd(2, 32'h000F0066, "R9");
        wr(2, 32'h00110022, 4'b1111);
        rd(2, 32'h000F0066, "R8");
        wr(3, 32'h000000C8, 4'b0001);
        wr(3, 32'h00000099, 4'b0001);
        rd(3, 32'h000000C8, "R8");
        warm_rst();
        rd(2, 32'h000F00A5, "R10");
        rd(3, 32'h000000C8, "R10");
        wr(2, 32'h00440055, 4'b0101);
        rd(2, 32'h00440055, "R9");
        cold_rst();
        rd(3, 32'h0000003C, "R10");
        rd(2, 32'h000F00A5, "R13");

        // R11 write-only command
        wr(3, 32'h0000AB00, 4'b0010);
        chk_pulse(F_CMD, 1'b1, "R11");
        chk_val(F_CMD, 8'hAB, "R11");
        rd(3, 32'h0000003C, "R11");
        chk_pulse(F_CMD, 1'b0, "R11");
        rd(3, 32'h0000003C, "R11");

        // R5 self-locking master key
        wr(3, 32'h00000000, 4'b1000);
        rd(3, 32'h0000003C, "R5");
        wr(1, 32'h00000044, 4'b0001);
        rd(1, 32'h22000044, "R5");
        wr(3, 32'h80000000, 4'b1000);
        rd(3, 32'h8000003C, "R5");
        wr(1, 32'h55015566, 4'b1111);
        rd(1, 32'h55000044, "R5");
        wr(3, 32'h00000000, 4'b1000);
        rd(3, 32'h8000003C, "R5");

        // R7 volatile under lock
        hw(F_VOL, 8'hF0, 8'h30);
        rd(1, 32'h5500F044, "R7");
        hw(F_VOL, 8'h00, 8'hC0);
        rd(1, 32'h55003044, "R7");

        // R12 warm reset releases master key
        warm_rst();
        rd(1, 32'h22000011, "R12");
        rd(3, 32'h0000003C, "R12");

        // R6 cascaded lock
        wr(1, 32'h00010000, 4'b0100);
        wr(1, 32'h77000000, 4'b1000);
        rd(1, 32'h22010011, "R6");
        wr(3, 32'h80000000, 4'b1000);
        wr(1, 32'h00000000, 4'b0100);
        chk_val(F_SUBKEY, 8'h01, "R6");
        rd(1, 32'h22010011, "R6");

        tick(); tick();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule